// File: doc/BRIEF.md
# UART Receiver with Error-Interrupt Routing

This block recovers characters from an asynchronous serial line. A prescaler divides the system clock by a programmable divisor to make a bit-timing tick, and 32 ticks make one bit period. While enabled, the receiver watches the synchronised line for a low level. It confirms the start bit at the middle of the bit. It then collects the data bits least-significant first, followed by one parity bit and one stop bit, each sampled at its own midpoint.

At the end of every frame the collected character is written into a receive buffer register, even when the frame is faulty. Sticky status bits record parity errors, framing errors and overruns until the buffer is read. Two single-cycle pulses report the frame. One marks completion and the other marks an error. A mask input decides whether a faulty frame also produces the completion pulse. Dropping the enable aborts a frame in progress without any trace on the buffer, the status or the pulses.

Top module: `uart_rx_route`

## Requirements
- R1: During and directly after reset, `rx_data` is 0 and all status bits and both pulses are 0.
- R2: The line is examined only while `rx_en` is 1. One bit period lasts `max(baud_div,1)*32` clock cycles.
- R3: A low level that is gone when the line is re-sampled 16 ticks after it was first seen is dropped, and no frame is received.
- R4: A frame consists of a low start bit, the data bits with bit 0 first, one parity bit and one stop bit. When a frame has no error, its data appears on `rx_data` and `irq_done` is high for exactly one cycle.
- R5: `par_mode` selects the parity check: 2'b01 even (data plus parity bit hold an even count of ones), 2'b10 odd, and 2'b00 or 2'b11 no check. A mismatch sets `st_parity`.
- R6: A low level sampled at the stop-bit midpoint sets `st_frame`.
- R7: A frame with any error still loads its data into `rx_data`.
- R8: For a faulty frame, `irq_done` pulses when `err_mask` is 0 and stays low when `err_mask` is 1.
- R9: `irq_err` is high for one cycle at the completion of any frame with a parity, framing or overrun error, whatever the setting of `err_mask`.
- R10: When a frame completes while the buffer holds an unread frame, `st_overrun` is set. A `buf_rd` pulse clears all three status bits and marks the buffer read. A read in the same cycle as a completion counts as reading the old frame, so no overrun is flagged and the status shows only the new frame.
- R11: Clearing `rx_en` in the middle of a frame stops reception immediately. `rx_data` and the status bits keep their values, and neither pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| par_mode | input | 2 | Parity check selection |
| err_mask | input | 1 | 1 suppresses completion pulse on faulty frames |
| baud_div | input | 8 | Prescaler divisor (0 acts as 1) |
| buf_rd | input | 1 | Buffer-read strobe, clears status |
| rx_line | input | 1 | Serial input line, idle high |
| rx_data | output | 8 | Receive buffer register |
| st_parity | output | 1 | Sticky parity error |
| st_frame | output | 1 | Sticky framing error |
| st_overrun | output | 1 | Sticky overrun error |
| irq_done | output | 1 | Receive-complete pulse |
| irq_err | output | 1 | Receive-error pulse |

## Verification
A buffer read and a frame completion can land on the same clock edge. In that case the read decides whether the new frame counts as an overrun and which status bits survive. The bench uses its own model to predict the edge that finishes the stop bit and raises `buf_rd` exactly in that cycle, while the buffer still holds an unread frame. The result is judged by `st_overrun` staying low, by the status showing only the new frame's errors, and by `rx_data` holding the new character with a single completion pulse.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } rx_phase_e;

    localparam logic [1:0] PCHK_EVEN = 2'b01;
    localparam logic [1:0] PCHK_ODD  = 2'b10;

    // odd_ones: XOR over data bits and received parity bit
    function automatic logic parity_fault(input logic [1:0] mode, input logic odd_ones);
        logic bad;
        case (mode)
            PCHK_EVEN: bad = odd_ones;
            PCHK_ODD:  bad = ~odd_ones;
            default:   bad = 1'b0;
        endcase
        return bad;
    endfunction

endpackage

// File: rtl/rx_tick_gen.sv
`timescale 1ns/1ps
module rx_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (div == '0) ? '0 : div - DIV_W'(1);
        tick  = en && (pre_q.cnt == limit);
        pre_d = pre_q;
        if (!en || tick) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/rx_bit_timer.sv
`timescale 1ns/1ps
module rx_bit_timer #(
    parameter int TICKS_PER_BIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic clr,
    output logic half_hit,
    output logic full_hit
);
    localparam int CW   = $clog2(TICKS_PER_BIT);
    localparam int HALF = TICKS_PER_BIT / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        half_hit = (tmr_q.cnt == CW'(HALF - 1));
        full_hit = (tmr_q.cnt == CW'(TICKS_PER_BIT - 1));
        tmr_d    = tmr_q;
        if (!en || clr) begin
            tmr_d.cnt = '0;
        end else if (tick) begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/rx_frame_ctrl.sv
`timescale 1ns/1ps
module rx_frame_ctrl
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 line_s,
    input  logic                 half_hit,
    input  logic                 full_hit,
    output logic                 timer_clr,
    output logic                 frame_done,
    output logic [DATA_BITS-1:0] frame_data,
    output logic                 frame_par,
    output logic                 frame_stop
);
    localparam int BW = $clog2(DATA_BITS + 1);

    typedef struct packed {
        rx_phase_e            phase;
        logic [BW-1:0]        nbits;
        logic [DATA_BITS-1:0] shreg;
        logic                 par;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        timer_clr  = 1'b0;
        frame_done = 1'b0;
        if (!en) begin
            fsm_d.phase = PH_IDLE;
            fsm_d.nbits = '0;
            timer_clr   = 1'b1;
        end else begin
            case (fsm_q.phase)
                PH_IDLE: begin
                    timer_clr = 1'b1;
                    if (tick && !line_s) fsm_d.phase = PH_START;
                end
                PH_START: begin
                    if (tick && half_hit) begin
                        timer_clr   = 1'b1;
                        fsm_d.nbits = '0;
                        fsm_d.phase = line_s ? PH_IDLE : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (tick && full_hit) begin
                        timer_clr   = 1'b1;
                        fsm_d.shreg = {line_s, fsm_q.shreg[DATA_BITS-1:1]};
                        fsm_d.nbits = fsm_q.nbits + BW'(1);
                        if (fsm_q.nbits == BW'(DATA_BITS - 1)) fsm_d.phase = PH_PARITY;
                    end
                end
                PH_PARITY: begin
                    if (tick && full_hit) begin
                        timer_clr   = 1'b1;
                        fsm_d.par   = line_s;
                        fsm_d.phase = PH_STOP;
                    end
                end
                PH_STOP: begin
                    if (tick && full_hit) begin
                        timer_clr   = 1'b1;
                        frame_done  = 1'b1;
                        fsm_d.phase = PH_IDLE;
                    end
                end
                default: fsm_d.phase = PH_IDLE;
            endcase
        end
        frame_data = fsm_q.shreg;
        frame_par  = fsm_q.par;
        frame_stop = line_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.phase <= PH_IDLE;
            fsm_q.nbits <= '0;
            fsm_q.shreg <= '0;
            fsm_q.par   <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end
endmodule

// File: rtl/rx_status_buf.sv
`timescale 1ns/1ps
module rx_status_buf
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] data_in,
    input  logic                 par_in,
    input  logic                 stop_in,
    input  logic [1:0]           par_mode,
    input  logic                 err_mask,
    input  logic                 buf_rd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 st_parity,
    output logic                 st_frame,
    output logic                 st_overrun,
    output logic                 irq_done,
    output logic                 irq_err
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 full;
        logic                 e_par;
        logic                 e_frm;
        logic                 e_ovr;
        logic                 p_done;
        logic                 p_err;
    } sts_t;

    sts_t sts_d, sts_q;
    logic bad_par, bad_frm, bad_ovr, any_bad;

    always_comb begin
        bad_par = parity_fault(par_mode, (^data_in) ^ par_in);
        bad_frm = ~stop_in;
        bad_ovr = sts_q.full && !buf_rd;
        any_bad = bad_par | bad_frm | bad_ovr;

        sts_d        = sts_q;
        sts_d.p_done = 1'b0;
        sts_d.p_err  = 1'b0;
        if (buf_rd) begin
            sts_d.full  = 1'b0;
            sts_d.e_par = 1'b0;
            sts_d.e_frm = 1'b0;
            sts_d.e_ovr = 1'b0;
        end
        if (done) begin
            sts_d.data   = data_in;
            sts_d.full   = 1'b1;
            sts_d.e_par  = sts_d.e_par | bad_par;
            sts_d.e_frm  = sts_d.e_frm | bad_frm;
            sts_d.e_ovr  = sts_d.e_ovr | bad_ovr;
            sts_d.p_err  = any_bad;
            sts_d.p_done = !any_bad || !err_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign rx_data    = sts_q.data;
    assign st_parity  = sts_q.e_par;
    assign st_frame   = sts_q.e_frm;
    assign st_overrun = sts_q.e_ovr;
    assign irq_done   = sts_q.p_done;
    assign irq_err    = sts_q.p_err;
endmodule

// File: rtl/uart_rx_route.sv
`timescale 1ns/1ps
module uart_rx_route #(
    parameter int DATA_BITS     = 8,
    parameter int DIV_W         = 8,
    parameter int TICKS_PER_BIT = 32,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic [1:0]           par_mode,
    input  logic                 err_mask,
    input  logic [DIV_W-1:0]     baud_div,
    input  logic                 buf_rd,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 st_parity,
    output logic                 st_frame,
    output logic                 st_overrun,
    output logic                 irq_done,
    output logic                 irq_err
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] taps;
    } sync_t;

    sync_t sync_d, sync_q;
    logic line_s, tick, half_hit, full_hit, timer_clr;
    logic frame_done, frame_par, frame_stop;
    logic [DATA_BITS-1:0] frame_data;

    always_comb begin
        sync_d      = sync_q;
        sync_d.taps = {sync_q.taps[SYNC_STAGES-2:0], rx_line};
        line_s      = sync_q.taps[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    rx_tick_gen #(.DIV_W(DIV_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .div(baud_div), .tick(tick)
    );

    rx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_timer (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .clr(timer_clr),
        .half_hit(half_hit), .full_hit(full_hit)
    );

    rx_frame_ctrl #(.DATA_BITS(DATA_BITS)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .line_s(line_s),
        .half_hit(half_hit), .full_hit(full_hit), .timer_clr(timer_clr),
        .frame_done(frame_done), .frame_data(frame_data),
        .frame_par(frame_par), .frame_stop(frame_stop)
    );

    rx_status_buf #(.DATA_BITS(DATA_BITS)) i_sts (
        .clk(clk), .rst_n(rst_n), .done(frame_done), .data_in(frame_data),
        .par_in(frame_par), .stop_in(frame_stop), .par_mode(par_mode),
        .err_mask(err_mask), .buf_rd(buf_rd), .rx_data(rx_data),
        .st_parity(st_parity), .st_frame(st_frame), .st_overrun(st_overrun),
        .irq_done(irq_done), .irq_err(irq_err)
    );
endmodule

// File: rtl/uart_rx_route_chk.sv
`timescale 1ns/1ps
module uart_rx_route_chk #(
    parameter int DATA_BITS = 8,
    parameter int DIV_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 err_mask,
    input logic                 buf_rd,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 st_parity,
    input logic                 st_frame,
    input logic                 st_overrun,
    input logic                 irq_done,
    input logic                 irq_err
);
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    assert_mask_routes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_err && $past(err_mask)) |-> !irq_done);

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |=> !irq_err);

    assert_overrun_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_overrun) |-> irq_err);

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |=> (irq_err || !(st_parity || st_frame || st_overrun)));

    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!irq_done && !irq_err));

    assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !buf_rd) |=> ($stable(rx_data) && $stable(st_parity)
                                 && $stable(st_frame) && $stable(st_overrun)));
endmodule

bind uart_rx_route uart_rx_route_chk #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) i_chk (.*);

// File: tb/test_uart_rx_route.sv
`timescale 1ns/1ps
module test_uart_rx_route;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic [1:0] par_mode = 2'b01;
    logic       err_mask = 1'b0;
    logic [7:0] baud_div = 8'd2;
    logic       buf_rd = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       st_parity, st_frame, st_overrun, irq_done, irq_err;

    int vectors = 0;
    int misses = 0;
    int n_done = 0;
    int n_err = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    uart_rx_route i_uart_rx_route (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .par_mode(par_mode),
        .err_mask(err_mask), .baud_div(baud_div), .buf_rd(buf_rd),
        .rx_line(rx_line), .rx_data(rx_data), .st_parity(st_parity),
        .st_frame(st_frame), .st_overrun(st_overrun), .irq_done(irq_done),
        .irq_err(irq_err)
    );

    // ---------------- behavioural reference model ----------------
    int   m_pre, m_cnt, m_phase, m_nbits;
    logic m_s1, m_s2;
    logic [7:0] m_bits, m_data;
    logic m_pbit, m_full, m_par, m_frm, m_ovr, m_idone, m_ierr;

    function automatic int period_of(input logic [7:0] d);
        return ((d == 0) ? 1 : int'(d)) * 32;
    endfunction

    function automatic logic m_tick_now();
        return rx_en && (m_pre == ((baud_div == 0) ? 0 : int'(baud_div) - 1));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_phase = 0; m_nbits = 0;
            m_s1 = 1; m_s2 = 1; m_bits = 0; m_data = 0; m_pbit = 0;
            m_full = 0; m_par = 0; m_frm = 0; m_ovr = 0; m_idone = 0; m_ierr = 0;
        end else begin
            logic tk, fin, stopv, was_full, ones, ep, ef, eo;
            tk = m_tick_now();
            fin = 0;
            stopv = 1;
            if (!rx_en) begin
                m_phase = 0; m_cnt = 0;
            end else if (tk) begin
                if (m_phase == 0) begin
                    if (!m_s2) m_phase = 1;
                    m_cnt = 0;
                end else if (m_phase == 1) begin
                    if (m_cnt == 15) begin
                        m_cnt = 0;
                        if (m_s2) m_phase = 0;
                        else begin m_phase = 2; m_nbits = 0; end
                    end else m_cnt++;
                end else if (m_cnt == 31) begin
                    m_cnt = 0;
                    if (m_phase == 2) begin
                        m_bits[m_nbits] = m_s2;
                        m_nbits++;
                        if (m_nbits == 8) m_phase = 3;
                    end else if (m_phase == 3) begin
                        m_pbit = m_s2; m_phase = 4;
                    end else begin
                        fin = 1; stopv = m_s2; m_phase = 0;
                    end
                end else m_cnt++;
            end
            m_pre = (!rx_en || tk) ? 0 : m_pre + 1;

            was_full = m_full;
            m_idone = 0; m_ierr = 0;
            if (buf_rd) begin m_full = 0; m_par = 0; m_frm = 0; m_ovr = 0; end
            if (fin) begin
                ones = ^{m_bits, m_pbit};
                ep = (par_mode == 2'b01 && ones) || (par_mode == 2'b10 && !ones);
                ef = !stopv;
                eo = was_full && !buf_rd;
                m_data = m_bits; m_full = 1;
                m_par = m_par | ep; m_frm = m_frm | ef; m_ovr = m_ovr | eo;
                m_ierr = ep | ef | eo;
                m_idone = !(ep | ef | eo) || !err_mask;
            end
            m_s2 = m_s1; m_s1 = rx_line;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        vectors++;
        if (irq_done) n_done++;
        if (irq_err)  n_err++;
        if ({rx_data, st_parity, st_frame, st_overrun, irq_done, irq_err} !==
            {m_data, m_par, m_frm, m_ovr, m_idone, m_ierr}) begin
            misses++;
            $display("FAIL %s t=%0t actual data=%h p=%b f=%b o=%b done=%b err=%b expected data=%h p=%b f=%b o=%b done=%b err=%b",
                     cur_req, $time, rx_data, st_parity, st_frame, st_overrun, irq_done, irq_err,
                     m_data, m_par, m_frm, m_ovr, m_idone, m_ierr);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pb, input logic sb);
        int p;
        p = period_of(baud_div);
        rx_line = 1'b0; idle(p);
        for (int i = 0; i < 8; i++) begin rx_line = d[i]; idle(p); end
        rx_line = pb; idle(p);
        rx_line = sb; idle(p);
        rx_line = 1'b1; idle(2 * p);
    endtask

    task automatic read_buf();
        buf_rd = 1'b1; idle(1); buf_rd = 1'b0; idle(1);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int d0, e0;
        idle(3);
        cur_req = "R1";
        chk("R1", {rx_data, st_parity, st_frame, st_overrun, irq_done, irq_err}, 0);
        rst_n = 1'b1; idle(2);
        chk("R1", {rx_data, st_parity, st_frame, st_overrun, irq_done, irq_err}, 0);

        cur_req = "R2";
        rx_line = 1'b0; idle(200); rx_line = 1'b1; idle(10);
        chk("R2", n_done + n_err, 0);
        rx_en = 1'b1; idle(5);

        cur_req = "R4";
        d0 = n_done;
        send_frame(8'hA5, ^8'hA5, 1'b1);
        chk("R4", rx_data, 8'hA5);
        chk("R4", n_done - d0, 1);
        read_buf();

        cur_req = "R2";
        rx_en = 1'b0; baud_div = 8'd0; idle(2); rx_en = 1'b1; idle(3);
        send_frame(8'h3C, ^8'h3C, 1'b1);
        chk("R2", rx_data, 8'h3C);
        read_buf();
        rx_en = 1'b0; baud_div = 8'd3; idle(2); rx_en = 1'b1; idle(3);
        send_frame(8'h81, ^8'h81, 1'b1);
        chk("R2", rx_data, 8'h81);
        read_buf();
        rx_en = 1'b0; baud_div = 8'd2; idle(2); rx_en = 1'b1; idle(3);

        cur_req = "R3";
        d0 = n_done;
        rx_line = 1'b0; idle(12); rx_line = 1'b1; idle(200);
        chk("R3", n_done - d0, 0);
        chk("R3", rx_data, 8'h81);

        cur_req = "R5";
        par_mode = 2'b10;
        send_frame(8'h0F, ~^8'h0F, 1'b1);
        chk("R5", st_parity, 0);
        read_buf();
        d0 = n_done; e0 = n_err;
        send_frame(8'h5A, ^8'h5A, 1'b1);
        chk("R5", st_parity, 1);
        chk("R7", rx_data, 8'h5A);
        chk("R8", n_done - d0, 1);
        chk("R9", n_err - e0, 1);
        read_buf();
        chk("R10", st_parity, 0);

        cur_req = "R6";
        err_mask = 1'b1; par_mode = 2'b01;
        d0 = n_done; e0 = n_err;
        send_frame(8'hC3, ^8'hC3, 1'b0);
        chk("R6", st_frame, 1);
        chk("R7", rx_data, 8'hC3);
        chk("R8", n_done - d0, 0);
        chk("R9", n_err - e0, 1);
        read_buf();

        cur_req = "R5";
        par_mode = 2'b00;
        send_frame(8'h77, ~^8'h77, 1'b1);
        chk("R5", st_parity, 0);
        par_mode = 2'b11;
        send_frame(8'h76, ^8'h77, 1'b1);
        chk("R5", st_parity, 0);
        chk("R10", st_overrun, 1);
        read_buf();
        chk("R10", st_overrun, 0);

        cur_req = "R10";
        par_mode = 2'b01; err_mask = 1'b0;
        send_frame(8'h11, ^8'h11, 1'b1);
        chk("R10", st_overrun, 0);
        d0 = n_done;
        fork
            send_frame(8'h22, ^8'h22, 1'b1);
            begin
                do @(negedge clk);
                while (!(m_phase == 4 && m_cnt == 31 && m_tick_now()));
                buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0;
            end
        join
        chk("R10", st_overrun, 0);
        chk("R10", rx_data, 8'h22);
        chk("R10", n_done - d0, 1);
        send_frame(8'h33, ^8'h33, 1'b1);
        chk("R10", st_overrun, 1);
        read_buf();

        cur_req = "R11";
        send_frame(8'h44, ^8'h44, 1'b0);
        d0 = n_done; e0 = n_err;
        rx_line = 1'b0; idle(64);
        rx_line = 1'b1; idle(64 * 3);
        rx_en = 1'b0; idle(300);
        rx_line = 1'b1; idle(10);
        chk("R11", n_done + n_err - d0 - e0, 0);
        chk("R11", rx_data, 8'h44);
        chk("R11", st_frame, 1);
        rx_en = 1'b1; idle(5);
        read_buf();
        send_frame(8'h99, ^8'h99, 1'b1);
        chk("R11", rx_data, 8'h99);
        idle(10);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule